// File: doc/BRIEF.md
# Challenge-Response Watchdog Answer Checker

This block judges whether a host controller answers a challenge-response watchdog correctly. Each watchdog cycle poses a 4-bit question. The host must return four answer bytes, one write at a time. The expected byte for each write depends on the current question and on a 2-bit answer counter that steps down from 3 to 0 as the answers arrive. The answers must be spread over two back-to-back response windows. An external timer marks the end of each window with a one-clock strobe.

When a cycle closes, the block decides whether it passed or failed. A pass lowers a saturating 3-bit failure count and moves to a fresh question taken from a small LFSR. A failure raises the count, keeps the same question and sets a sticky error flag, which the host clears by writing a one. The block also raises a threshold output whenever the failure count reaches a limit that software programs. Each verdict is reported as a one-clock pulse.

Top module: `qaw_evaluator`

## Requirements
- R1: The expected byte for a question q and answer counter c is the XOR of 8'h4F, 8'h16, 8'h8A and 8'h2D, each included when bit 0, 1, 2 or 3 of q is set, then XORed with {{4{c[0]}},{4{c[1]}}}. For example, question 0x0 expects FF, 0F, F0, 00 for c = 3, 2, 1, 0, and question 0xF expects 01, F1, 0E, FE.
- R2: `answerCnt` is 3 after reset and at the start of every cycle. It drops by one on each accepted write, and at most one write is taken per clock.
- R3: A cycle passes only if three correct answers arrive in window 1 and a fourth correct answer arrives in window 2. The cycle ends on that fourth write, and `cycleDone` and `cyclePass` are both high in the following clock.
- R4: On a pass, `failCount` drops by one but not below 0, and `question` advances to {q[2:0], ~(q[3]^q[2])}. `qaErr` is not set. On any clock that is not a pass, `question` holds.
- R5: A fourth write that does not meet R3 ends the cycle as a failure at once. This covers four answers in window 1, a 2+2 split, and any incorrect byte. `failCount` rises by one but not above 7, `question` is kept, and `qaErr` is set. `cycleDone` is high with `cyclePass` low in the following clock.
- R6: A window-2-end strobe that arrives while fewer than four answers have been written ends the cycle as a failure, with the same effects as R5. This includes the case of no answers at all.
- R7: A write in the same clock as a window-end strobe counts in the window that is ending.
- R8: A window-1-end strobe during window 2 and a window-2-end strobe during window 1 have no effect.
- R9: `qaErr` stays set until a clock with `errClr` high. If a failure occurs in the same clock as the clear, the flag stays set.
- R10: `failAlarm` is high exactly when `failCount` >= `failLimit`.
- R11: After reset, `question` is 0, `failCount` is 0, and `qaErr`, `cycleDone` and `cyclePass` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ansWrEn | input | 1 | Answer write strobe |
| ansData | input | 8 | Answer byte |
| win1End | input | 1 | One-clock strobe marking the end of window 1 |
| win2End | input | 1 | One-clock strobe marking the end of window 2 |
| errClr | input | 1 | Write-one-to-clear for the error flag |
| failLimit | input | 3 | Failure count threshold |
| question | output | 4 | Current question |
| answerCnt | output | 2 | Answer counter |
| qaErr | output | 1 | Sticky error flag |
| failCount | output | 3 | Saturating failure count |
| failAlarm | output | 1 | Failure count at or above the limit |
| cycleDone | output | 1 | Pulse: a cycle has closed |
| cyclePass | output | 1 | Pulse: the cycle that closed passed |

## Verification
If the window phase or the answer tally were wrong, a verdict pulse would arrive on the wrong write or on the wrong strobe, or carry the wrong pass bit. The scoreboard sees this in the clock right after the cycle closes. A corrupted answer counter shows up on `answerCnt` one clock after the write that caused it. It also turns later correct answers into failures before the same cycle ends. A wrong LFSR step or a wrong saturation bound appears on `question` or `failCount` with the next verdict.

// File: rtl/qaw_pkg.sv
`timescale 1ns/1ps
package qaw_pkg;
  localparam int QW = 4;          // question width
  localparam int BW = 8;          // answer byte width
  localparam int CW = 2;          // answer counter width
  localparam int FW = 3;          // failure counter width
  localparam int ANSWERS = 1 << CW;
  localparam logic [FW-1:0] FAIL_MAX = {FW{1'b1}};
  localparam logic [CW-1:0] CNT_START = {CW{1'b1}};

  // one generator byte per question bit; expected byte is linear in the question
  localparam logic [BW-1:0] ANSWER_GEN [QW] = '{8'h4F, 8'h16, 8'h8A, 8'h2D};

  typedef struct packed {
    logic endCycle;
    logic passCycle;
  } qawStrobe_t;

  function automatic logic [QW-1:0] lfsrNext(input logic [QW-1:0] q);
    return {q[QW-2:0], ~(q[QW-1] ^ q[QW-2])};
  endfunction
endpackage

// File: rtl/qaw_control.sv
`timescale 1ns/1ps
module qaw_control
  import qaw_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          ansWrEn,
  input  logic          ansMatch,
  input  logic          win1End,
  input  logic          win2End,
  output logic [CW-1:0] answerCnt,
  output qawStrobe_t    strobe
);
  localparam int RW = CW + 1;
  localparam logic [RW-1:0] LAST_IDX = RW'(ANSWERS - 1);
  localparam logic [RW-1:0] WIN1_NEED = RW'(ANSWERS - 1);

  logic          inWin2;
  logic [RW-1:0] rcvdCnt;
  logic [RW-1:0] win1Cnt;
  logic          badSeen;
  logic          fourthWr;
  logic          passNow;
  logic          timeoutEnd;

  always_comb begin
    fourthWr   = ansWrEn && (rcvdCnt == LAST_IDX);
    passNow    = fourthWr && inWin2 && (win1Cnt == WIN1_NEED) && !badSeen && ansMatch;
    timeoutEnd = win2End && inWin2 && !fourthWr;
    strobe.endCycle  = fourthWr || timeoutEnd;
    strobe.passCycle = passNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inWin2    <= 1'b0;
      answerCnt <= CNT_START;
      rcvdCnt   <= '0;
      win1Cnt   <= '0;
      badSeen   <= 1'b0;
    end else if (strobe.endCycle) begin
      inWin2    <= 1'b0;
      answerCnt <= CNT_START;
      rcvdCnt   <= '0;
      win1Cnt   <= '0;
      badSeen   <= 1'b0;
    end else begin
      if (ansWrEn) begin
        rcvdCnt   <= rcvdCnt + 1'b1;
        answerCnt <= answerCnt - 1'b1;
        if (!inWin2) win1Cnt <= win1Cnt + 1'b1;
        if (!ansMatch) badSeen <= 1'b1;
      end
      if (win1End && !inWin2) inWin2 <= 1'b1;
    end
  end
endmodule

// File: rtl/qaw_datapath.sv
`timescale 1ns/1ps
module qaw_datapath
  import qaw_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [BW-1:0] ansData,
  input  logic [CW-1:0] answerCnt,
  input  qawStrobe_t    strobe,
  input  logic          errClr,
  input  logic [FW-1:0] failLimit,
  output logic          ansMatch,
  output logic [QW-1:0] question,
  output logic          qaErr,
  output logic [FW-1:0] failCount,
  output logic          failAlarm,
  output logic          cycleDone,
  output logic          cyclePass
);
  localparam int HALF = BW / 2;

  logic [BW-1:0] term [QW];
  logic [BW-1:0] baseByte;
  logic [BW-1:0] expByte;

  for (genvar g = 0; g < QW; g++) begin : g_term
    assign term[g] = question[g] ? ANSWER_GEN[g] : '0;
  end

  always_comb begin
    baseByte = '0;
    for (int i = 0; i < QW; i++) baseByte = baseByte ^ term[i];
    expByte  = baseByte ^ {{HALF{answerCnt[0]}}, {HALF{answerCnt[1]}}};
    ansMatch = (ansData == expByte);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      question  <= '0;
      failCount <= '0;
      qaErr     <= 1'b0;
      cycleDone <= 1'b0;
      cyclePass <= 1'b0;
    end else begin
      cycleDone <= strobe.endCycle;
      cyclePass <= strobe.endCycle && strobe.passCycle;
      if (strobe.endCycle && strobe.passCycle) begin
        question <= lfsrNext(question);
        if (failCount != '0) failCount <= failCount - 1'b1;
        if (errClr) qaErr <= 1'b0;
      end else if (strobe.endCycle) begin
        if (failCount != FAIL_MAX) failCount <= failCount + 1'b1;
        qaErr <= 1'b1;
      end else if (errClr) begin
        qaErr <= 1'b0;
      end
    end
  end

  assign failAlarm = (failCount >= failLimit);
endmodule

// File: rtl/qaw_evaluator.sv
`timescale 1ns/1ps
module qaw_evaluator
  import qaw_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          ansWrEn,
  input  logic [BW-1:0] ansData,
  input  logic          win1End,
  input  logic          win2End,
  input  logic          errClr,
  input  logic [FW-1:0] failLimit,
  output logic [QW-1:0] question,
  output logic [CW-1:0] answerCnt,
  output logic          qaErr,
  output logic [FW-1:0] failCount,
  output logic          failAlarm,
  output logic          cycleDone,
  output logic          cyclePass
);
  qawStrobe_t strobe;
  logic       ansMatch;

  qaw_control u_ctrl (
    .clk(clk), .rstN(rstN), .ansWrEn(ansWrEn), .ansMatch(ansMatch),
    .win1End(win1End), .win2End(win2End),
    .answerCnt(answerCnt), .strobe(strobe)
  );

  qaw_datapath u_dp (
    .clk(clk), .rstN(rstN), .ansData(ansData), .answerCnt(answerCnt),
    .strobe(strobe), .errClr(errClr), .failLimit(failLimit),
    .ansMatch(ansMatch), .question(question), .qaErr(qaErr),
    .failCount(failCount), .failAlarm(failAlarm),
    .cycleDone(cycleDone), .cyclePass(cyclePass)
  );
endmodule

// File: rtl/qaw_checker.sv
`timescale 1ns/1ps
module qaw_checker
  import qaw_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic [QW-1:0] question,
  input logic [CW-1:0] answerCnt,
  input logic          qaErr,
  input logic [FW-1:0] failCount,
  input logic          cycleDone,
  input logic          cyclePass
);
  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> answerCnt == CNT_START);

  // R3
  pass_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cyclePass |-> cycleDone);

  // R4
  pass_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && cyclePass) |->
      failCount == (($past(failCount) == '0) ? '0 : FW'($past(failCount) - 1'b1)));

  // R4
  q_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cycleDone && cyclePass) |-> $stable(question));

  // R5
  fail_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && !cyclePass) |->
      qaErr && failCount == (($past(failCount) == FAIL_MAX) ? FAIL_MAX : FW'($past(failCount) + 1'b1)));

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qaErr) |-> (cycleDone && !cyclePass));
endmodule

bind qaw_evaluator qaw_checker u_chk (
  .clk(clk), .rstN(rstN), .question(question), .answerCnt(answerCnt),
  .qaErr(qaErr), .failCount(failCount), .cycleDone(cycleDone), .cyclePass(cyclePass)
);

// File: tb/qaw_evaluator_test.sv
`timescale 1ns/1ps
module qaw_evaluator_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ansWrEn = 1'b0;
  logic [7:0] ansData = '0;
  logic       win1End = 1'b0;
  logic       win2End = 1'b0;
  logic       errClr = 1'b0;
  logic [2:0] failLimit = 3'd3;
  logic [3:0] question;
  logic [1:0] answerCnt;
  logic       qaErr;
  logic [2:0] failCount;
  logic       failAlarm;
  logic       cycleDone;
  logic       cyclePass;

  qaw_evaluator uut (
    .clk(clk), .rstN(rstN), .ansWrEn(ansWrEn), .ansData(ansData),
    .win1End(win1End), .win2End(win2End), .errClr(errClr), .failLimit(failLimit),
    .question(question), .answerCnt(answerCnt), .qaErr(qaErr),
    .failCount(failCount), .failAlarm(failAlarm),
    .cycleDone(cycleDone), .cyclePass(cyclePass)
  );

  always #5 clk = ~clk;

  typedef struct {
    bit       pass;
    bit [3:0] q;
    bit [2:0] fc;
    bit       err;
  } item_t;

  item_t expQ[$];
  string tagQ[$];
  string curTag = "R3";
  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 0;

  // reference model state
  bit [3:0] mq = 0;
  bit [1:0] mcnt = 3;
  int       mrcvd = 0;
  int       mw1 = 0;
  bit       mbad = 0;
  bit       mW2 = 0;
  bit [2:0] mfc = 0;
  bit       merr = 0;

  function automatic bit [7:0] expB(input bit [3:0] q, input bit [1:0] c);
    bit [7:0] b;
    case (q)
      4'h0: b = 8'h00; 4'h1: b = 8'h4F; 4'h2: b = 8'h16; 4'h3: b = 8'h59;
      4'h4: b = 8'h8A; 4'h5: b = 8'hC5; 4'h6: b = 8'h9C; 4'h7: b = 8'hD3;
      4'h8: b = 8'h2D; 4'h9: b = 8'h62; 4'hA: b = 8'h3B; 4'hB: b = 8'h74;
      4'hC: b = 8'hA7; 4'hD: b = 8'hE8; 4'hE: b = 8'hB1; default: b = 8'hFE;
    endcase
    case (c)
      2'd0: return b;
      2'd1: return b ^ 8'hF0;
      2'd2: return b ^ 8'h0F;
      default: return b ^ 8'hFF;
    endcase
  endfunction

  function automatic bit [3:0] nextQ(input bit [3:0] q);
    return {q[2:0], ~(q[3] ^ q[2])};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one clock of stimulus, model update, expectation push
  task automatic step(input bit wr, input bit good, input bit e1, input bit e2, input bit clr);
    bit ended;
    bit passed;
    ended = 0;
    passed = 0;
    @(negedge clk);
    ansWrEn = wr;
    ansData = expB(mq, mcnt) ^ (good ? 8'h00 : 8'h5A);
    win1End = e1;
    win2End = e2;
    errClr  = clr;
    @(posedge clk);
    #1;
    ansWrEn = 0; win1End = 0; win2End = 0; errClr = 0;
    if (wr) begin
      if (!mW2) mw1++;
      if (!good) mbad = 1;
      mrcvd++;
      mcnt--;
      if (mrcvd == 4) begin
        ended = 1;
        passed = mW2 && (mw1 == 3) && !mbad;
      end
    end
    if (!ended && e2 && mW2) ended = 1;
    if (!ended && e1 && !mW2) mW2 = 1;
    if (clr) merr = 0;
    if (ended) begin
      if (passed) begin
        if (mfc != 0) mfc--;
        mq = nextQ(mq);
      end else begin
        if (mfc != 7) mfc++;
        merr = 1;
      end
      mW2 = 0; mw1 = 0; mrcvd = 0; mbad = 0; mcnt = 3;
      expQ.push_back('{passed, mq, mfc, merr});
      tagQ.push_back(curTag);
    end
    check(answerCnt == mcnt, "R2", answerCnt, mcnt);
    check(qaErr == merr, "R9", qaErr, merr);
    check(failAlarm == (mfc >= failLimit), "R10", failAlarm, (mfc >= failLimit));
  endtask

  task automatic goodPass();
    step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(1, 1, 0, 0, 0);
  endtask

  // monitor: pop an expected verdict on every cycleDone pulse
  always @(negedge clk) begin
    if (rstN && cycleDone && !finished) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFail++;
        $display("FAIL R8: unexpected cycle end, actual 1 expected 0 at %0t", $time);
      end else begin
        item_t it;
        string t;
        it = expQ.pop_front();
        t  = tagQ.pop_front();
        check(cyclePass == it.pass, t, cyclePass, it.pass);
        check(question == it.q, t, question, it.q);
        check(failCount == it.fc, t, failCount, it.fc);
        check(qaErr == it.err, t, qaErr, it.err);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(question == 0, "R11", question, 0);
    check(failCount == 0, "R11", failCount, 0);
    check(qaErr == 0, "R11", qaErr, 0);
    check(cycleDone == 0 && cyclePass == 0, "R11", cycleDone, 0);
    check(answerCnt == 3, "R2", answerCnt, 3);
    // R1 expected bytes for question 0 and 15 from the table
    check(expB(4'h0, 3) == 8'hFF && expB(4'h0, 2) == 8'h0F, "R1", expB(4'h0, 3), 8'hFF);
    check(expB(4'hF, 1) == 8'h0E, "R1", expB(4'hF, 1), 8'h0E);

    curTag = "R3"; goodPass();                       // R1 bytes accepted on question 0
    curTag = "R6"; step(0, 0, 1, 0, 0); step(0, 0, 0, 1, 0);
    curTag = "R9"; step(0, 0, 0, 0, 1);
    curTag = "R5";                                   // four answers in window 1
    repeat (4) step(1, 1, 0, 0, 0);
    curTag = "R5";                                   // 2+2 split
    step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0); step(0, 0, 1, 0, 0);
    step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0);
    curTag = "R5";                                   // wrong final byte
    step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0); step(1, 0, 0, 0, 0);
    curTag = "R5";                                   // wrong byte in window 1
    step(1, 1, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0); step(1, 1, 0, 0, 0);
    curTag = "R7";                                   // third write with window-1 end
    step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 1, 0, 0);
    step(1, 1, 0, 0, 0);
    curTag = "R7";                                   // fourth write with window-2 end
    step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0); step(1, 1, 0, 1, 0);
    curTag = "R8";                                   // misplaced strobes ignored
    step(0, 0, 0, 1, 0);
    step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0); step(0, 0, 1, 0, 0);
    step(1, 1, 0, 0, 0);
    curTag = "R9";                                   // fail beats clear
    step(0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0); step(0, 0, 0, 1, 1);
    curTag = "R6";                                   // saturate at 7
    repeat (5) begin step(0, 0, 1, 0, 0); step(0, 0, 0, 1, 0); end
    curTag = "R4";                                   // count down, walk the LFSR
    repeat (9) goodPass();
    repeat (3) step(0, 0, 0, 0, 0);
    check(expQ.size() == 0, "R3", expQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule